// File: doc/BRIEF.md
# Serial-Addressed Memory Read Router

The router takes one framed serial bit stream and turns each frame into a single read from an external byte-wide synchronous memory. A strobe input stays high for the cycles that carry frame bits. The first two bits pick one of four output channels. The remaining bits, from zero up to sixteen of them, form the read address, most significant bit first. The fetched byte is stored in the register of the chosen channel. The other channels keep whatever they held before.

Once the byte is stored, the router shows the contents of all four channel registers on its outputs for exactly one cycle and raises a done flag in that same cycle. In every other cycle the channel outputs read zero. The memory port only ever reads: its write-enable is tied low, and its enable is raised for the two cycles of the access, the request cycle and the capture cycle. A synchronous active-high reset clears all stored state and returns the block to idle.

Top module: `serial_read_router`

## Requirements
- R1: The first serial bit of a frame is the upper selector bit and the second is the lower one. Selector value 0, 1, 2 or 3 routes the fetched byte to `ch0_o`, `ch1_o`, `ch2_o` or `ch3_o` respectively.
- R2: Address bits are shifted in MSB-first on the strobe-high cycles after the selector. An address of N bits (N < 16) appears on `mem_addr_o` zero-extended in its upper bits.
- R3: A frame writes only the selected channel register. The other three registers keep their earlier values, and those values appear at the next done pulse.
- R4: `mem_we_o` is 0 in every cycle.
- R5: `mem_en_o` is high for exactly two consecutive cycles per frame and low in all other cycles.
- R6: `done_o` is high for exactly one cycle per frame.
- R7: All four channel outputs are zero in every cycle where `done_o` is low. When `done_o` is high they show the stored channel values.
- R8: The address register is cleared when a new frame starts, so a short address never inherits bits from an earlier frame.
- R9: A frame whose strobe is high for only two cycles reads address 0.
- R10: When the strobe falls after the last frame bit, `mem_en_o` rises on the next clock edge, and `done_o` is high during the third cycle after the strobe falls.
- R11: Reset clears all channel registers and the address, and it drives every output to zero, including a reset that arrives in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Frame strobe, high while frame bits are on `bit_i` |
| bit_i | input | 1 | Serial frame data |
| mem_addr_o | output | 16 | Memory read address |
| mem_en_o | output | 1 | Memory enable |
| mem_we_o | output | 1 | Memory write enable, always 0 |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after enable |
| ch0_o | output | 8 | Channel 0 output |
| ch1_o | output | 8 | Channel 1 output |
| ch2_o | output | 8 | Channel 2 output |
| ch3_o | output | 8 | Channel 3 output |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The embedded assertions watch several properties on every cycle. They check that done is a single-cycle pulse that comes right after a capture, that the channel outputs stay at zero outside that pulse, that the memory enable window lasts exactly two cycles, that the address clears at the start of each frame and shifts the new bit into its low end, and that unselected channel registers do not change when data is captured. Other properties only the bench scenarios can show. These are the correct channel mapping, the zero-extended address value, the fetched byte, the exact latency from the falling strobe, and the effect of a reset in mid-frame. The bench covers them with frames of random length and content and with directed frames of zero and sixteen address bits.

// File: rtl/router_pkg.sv
package router_pkg;
  typedef enum logic [2:0] {
    ST_SEL_HI,
    ST_SEL_LO,
    ST_ADDR,
    ST_REQ,
    ST_CAPT,
    ST_SHOW
  } rt_state_e;
endpackage

// File: rtl/router_ctrl.sv
module router_ctrl
  import router_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             bit_i,
  output logic             clr_o,
  output logic             shift_o,
  output logic             mem_en_o,
  output logic             capture_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             done_o
);
  rt_state_e        state_q;
  logic [SEL_W-1:0] sel_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SEL_HI;
      sel_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_CAPT);
      case (state_q)
        ST_SEL_HI: if (start_i) begin
          sel_q   <= {bit_i, {(SEL_W-1){1'b0}}};
          state_q <= ST_SEL_LO;
        end
        ST_SEL_LO: begin
          sel_q[0] <= bit_i;
          state_q  <= ST_ADDR;
        end
        ST_ADDR:  if (!start_i) state_q <= ST_REQ;
        ST_REQ:   state_q <= ST_CAPT;
        ST_CAPT:  state_q <= ST_SHOW;
        ST_SHOW:  state_q <= ST_SEL_HI;
        default:  state_q <= ST_SEL_HI;
      endcase
    end
  end

  assign clr_o     = (state_q == ST_SEL_HI) && start_i;
  assign shift_o   = (state_q == ST_ADDR) && start_i;
  assign mem_en_o  = (state_q == ST_REQ) || (state_q == ST_CAPT);
  assign capture_o = (state_q == ST_CAPT);
  assign sel_o     = sel_q;
  assign done_o    = done_q;

  assert_en_second_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_en_o) |=> mem_en_o);
  assert_en_window_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_en_o && $past(mem_en_o)) |=> !mem_en_o);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_done_after_capture_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(capture_o));
endmodule

// File: rtl/router_addr_shift.sv
module router_addr_shift #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) addr_q <= '0;
    else if (shift_i) addr_q <= {addr_q[ADDR_W-2:0], bit_i};
  end

  assign addr_o = addr_q;

  assert_frame_clears_addr_R8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (addr_o == '0));
  assert_shift_lsb_in_R2: assert property (@(posedge clk) disable iff (rst)
    shift_i |=> (addr_o[0] == $past(bit_i)));
endmodule

// File: rtl/router_chan_bank.sv
module router_chan_bank #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          capture_i,
  input  logic [SEL_W-1:0]              sel_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [NUM_CH-1:0][DATA_W-1:0] out_o
);
  logic [NUM_CH-1:0][DATA_W-1:0] reg_q;
  logic [NUM_CH-1:0][DATA_W-1:0] out_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = capture_i && (sel_i == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        reg_q[g] <= '0;
        out_q[g] <= '0;
      end else begin
        if (hit) reg_q[g] <= wdata_i;
        out_q[g] <= capture_i ? (hit ? wdata_i : reg_q[g]) : '0;
      end
    end

    assert_hold_unselected_R3: assert property (@(posedge clk) disable iff (rst)
      (capture_i && (sel_i != SEL_W'(g))) |=> $stable(reg_q[g]));
  end

  assign out_o = out_q;
endmodule

// File: rtl/serial_read_router.sv
module serial_read_router #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              bit_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] ch0_o,
  output logic [DATA_W-1:0] ch1_o,
  output logic [DATA_W-1:0] ch2_o,
  output logic [DATA_W-1:0] ch3_o,
  output logic              done_o
);
  localparam int NUM_CH = 4;
  localparam int SEL_W  = $clog2(NUM_CH);

  logic                          clr, shift, capture;
  logic [SEL_W-1:0]              sel;
  logic [NUM_CH-1:0][DATA_W-1:0] chans;

  router_ctrl #(.SEL_W(SEL_W)) ctrl_i (
    .clk(clk), .rst(rst), .start_i(start_i), .bit_i(bit_i),
    .clr_o(clr), .shift_o(shift), .mem_en_o(mem_en_o),
    .capture_o(capture), .sel_o(sel), .done_o(done_o)
  );

  router_addr_shift #(.ADDR_W(ADDR_W)) addr_i (
    .clk(clk), .rst(rst), .clr_i(clr), .shift_i(shift),
    .bit_i(bit_i), .addr_o(mem_addr_o)
  );

  router_chan_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .SEL_W(SEL_W)) bank_i (
    .clk(clk), .rst(rst), .capture_i(capture), .sel_i(sel),
    .wdata_i(mem_rdata_i), .out_o(chans)
  );

  assign mem_we_o = 1'b0;
  assign ch0_o    = chans[0];
  assign ch1_o    = chans[1];
  assign ch2_o    = chans[2];
  assign ch3_o    = chans[3];

  assert_quiet_outputs_R7: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> (chans == '0));
endmodule

// File: tb/serial_read_router_tb_top.sv
module serial_read_router_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        bit_i = 1'b0;
  logic [15:0] mem_addr_o;
  logic        mem_en_o, mem_we_o, done_o;
  logic [7:0]  mem_rdata_i = '0;
  logic [7:0]  ch0_o, ch1_o, ch2_o, ch3_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_ch [4];

  always #2.5 clk = ~clk;

  serial_read_router dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .bit_i(bit_i),
    .mem_addr_o(mem_addr_o), .mem_en_o(mem_en_o), .mem_we_o(mem_we_o),
    .mem_rdata_i(mem_rdata_i), .ch0_o(ch0_o), .ch1_o(ch1_o),
    .ch2_o(ch2_o), .ch3_o(ch3_o), .done_o(done_o)
  );

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  always @(posedge clk) if (mem_en_o) mem_rdata_i <= mem_fn(mem_addr_o);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_quiet(input string req);
    chk(done_o == 1'b0, {req, " done low"}, done_o, 0);
    chk({ch0_o, ch1_o, ch2_o, ch3_o} == 32'h0, "R7 outputs zero", {ch0_o, ch1_o, ch2_o, ch3_o}, 0);
    chk(mem_we_o == 1'b0, "R4 write enable", mem_we_o, 0);
  endtask

  task automatic frame(input logic [1:0] sel, input int n, input logic [15:0] a);
    logic [15:0] ea;
    ea = (n == 0) ? 16'h0 : 16'(a & ((32'h1 << n) - 1));
    @(negedge clk); start_i = 1'b1; bit_i = sel[1];
    @(negedge clk); bit_i = sel[0];
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); bit_i = a[i];
    end
    @(negedge clk); start_i = 1'b0; bit_i = 1'($urandom);
    exp_ch[sel] = mem_fn(ea);
    @(negedge clk);
    chk_quiet("R10");
    chk(mem_en_o == 1'b1, "R10 enable rises after strobe falls", mem_en_o, 1);
    @(negedge clk);
    chk_quiet("R10");
    chk(mem_en_o == 1'b1, "R5 enable second cycle", mem_en_o, 1);
    @(negedge clk);
    chk(done_o == 1'b1, "R10 done latency", done_o, 1);
    chk(mem_en_o == 1'b0, "R5 enable low after window", mem_en_o, 0);
    chk(mem_addr_o == ea, (n == 0) ? "R9 zero-bit address" : "R2 R8 address",
        mem_addr_o, ea);
    chk({ch0_o, ch1_o, ch2_o, ch3_o} == {exp_ch[0], exp_ch[1], exp_ch[2], exp_ch[3]},
        "R1 R3 channel values", {ch0_o, ch1_o, ch2_o, ch3_o},
        {exp_ch[0], exp_ch[1], exp_ch[2], exp_ch[3]});
    @(negedge clk);
    chk_quiet("R6");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20230611));
    for (int c = 0; c < 4; c++) exp_ch[c] = '0;
    repeat (4) @(negedge clk);
    chk_quiet("R11 reset");
    chk(mem_addr_o == 16'h0 && mem_en_o == 1'b0, "R11 reset memory port",
        {mem_en_o, mem_addr_o}, 0);
    rst = 1'b0;
    // R9: zero-bit frame, R1 each channel
    frame(2'b00, 0, 16'hFFFF);
    frame(2'b01, 16, 16'hFFFF);
    // R8: short frame after all-ones address must not inherit bits
    frame(2'b10, 1, 16'h0001);
    frame(2'b11, 3, 16'h0005);
    frame(2'b11, 0, 16'h0000);
    for (int k = 0; k < 40; k++) begin
      frame(2'($urandom), int'($urandom_range(0, 16)), 16'($urandom));
    end
    // R11: reset in the middle of a frame
    @(negedge clk); start_i = 1'b1; bit_i = 1'b1;
    repeat (5) begin @(negedge clk); bit_i = 1'($urandom); end
    rst = 1'b1; start_i = 1'b0;
    for (int c = 0; c < 4; c++) exp_ch[c] = '0;
    @(negedge clk);
    chk_quiet("R11 mid-frame reset");
    chk(mem_addr_o == 16'h0, "R11 address cleared", mem_addr_o, 0);
    rst = 1'b0;
    frame(2'b01, 8, 16'h00C3);
    repeat (3) @(negedge clk);
    chk_quiet("R7 idle");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule